// File: doc/BRIEF.md
# SPI Flash Serial Read Engine

This block is the read side of a serial flash slave. The host lowers chip-select and clocks in an 8-bit command and a 24-bit start address on SI, one bit per rising SCLK edge, most significant bit first. The block then streams memory bytes out on SO, one bit per falling SCLK edge, for as long as the host keeps clocking. Two commands are recognised. The plain read starts data on the falling edge right after the last address bit. The fast read first takes one extra byte of don't-care clocks. The fast read is refused while a program or erase cycle elsewhere in the device holds the busy input high.

The serial pins are sampled in the system clock domain. They pass through a short synchronizer and an edge detector, so SCLK must be several system clocks slower than `clk`. Bytes come from a synchronous read port that has one cycle of latency. After each byte the address advances by one and wraps from the top of the array to zero, so a single command can stream the whole array. Raising chip-select ends the command at any point and returns SO to high impedance.

Top module: `spi_flash_reader`

## Requirements
- R1: After reset, `soOe` and `memRdEn` are low.
- R2: Command 03h (MSB first) followed by a 24-bit address (MSB first) starts a plain read. The MSB of the byte at that address appears on SO after the falling SCLK edge that follows the last address bit, with no clocks in between.
- R3: SO changes only in response to a falling SCLK edge. It holds its value while SCLK is high.
- R4: Command 0Bh is a fast read. After the address, eight further SCLK clocks are ignored, and the first data bit follows the falling edge of the eighth of them.
- R5: Bytes are output MSB first. Each following byte comes from the next higher address.
- R6: Only the low log2(MEM_BYTES) address bits are used. After address MEM_BYTES-1 the stream continues at address 0.
- R7: Raising `csN` at any time ends the command. `soOe` goes low, and the next command after `csN` falls again is decoded normally.
- R8: A 0Bh command received while `busy` is high is refused. `soOe` stays low and no memory read is issued until `csN` rises.
- R9: `busy` has no effect on a 03h command.
- R10: Any other command byte is ignored until `csN` rises. No memory read is issued and `soOe` stays low, whatever bits follow.
- R11: `soOe` is low during the command, address and dummy bits. It is high only while data is being shifted out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than SCLK |
| rstN | input | 1 | Active-low synchronous reset |
| sclk | input | 1 | Serial clock from the host |
| csN | input | 1 | Active-low chip select |
| si | input | 1 | Serial data in |
| busy | input | 1 | High while a program or erase cycle is running |
| so | output | 1 | Serial data out |
| soOe | output | 1 | Output enable for SO; low means high impedance |
| memRdEn | output | 1 | Read strobe to the array port |
| memAddr | output | log2(MEM_BYTES) | Byte address of the array read |
| memRdata | input | 8 | Array data, valid one clock after `memRdEn` |

## Verification
Each SCLK edge reaches the logic three clocks after the pin changes: two synchronizer stages and one edge register. A new SO bit is therefore stable about four clocks after a falling edge, and `soOe` drops about four clocks after `csN` rises. The bench holds each SCLK level for eight clocks. It compares SO with the bit popped from its reference queue at the end of each low phase, and compares SO again in the middle of the high phase. It checks `soOe` eight clocks after `csN` rises. It counts memory strobes across whole commands, so refused and ignored commands are judged at the ports and not at a single edge.

// File: rtl/spi_rd_pkg.sv
package spi_rd_pkg;

  localparam logic [7:0] OP_READ = 8'h03;
  localparam logic [7:0] OP_FAST = 8'h0B;

  localparam int ADDR_BITS_IN = 24;
  localparam int DUMMY_BITS   = 8;

  typedef enum logic [2:0] {
    ST_CMD,
    ST_ADDR,
    ST_DUMMY,
    ST_DATA,
    ST_IGNORE
  } rdState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftIn;   // capture SI on a rising edge
    logic loadAddr;  // last address bit: load the start address
    logic fetch;     // request one byte from the array
    logic loadOut;   // first bit of a byte: load output shifter
    logic shiftOut;  // later bits: shift output
    logic oeClr;     // chip select inactive
  } dpCtrl_t;

endpackage

// File: rtl/spi_rd_sync.sv
module spi_rd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclk,
  input  logic csN,
  input  logic si,
  output logic sclkRise,
  output logic sclkFall,
  output logic csActive,
  output logic siS
);

  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] sclkQ;
  logic [STAGES-1:0] csQ;
  logic [STAGES-1:0] siQ;
  logic              sclkPrev;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclkQ    <= '0;
      csQ      <= '1;
      siQ      <= '0;
      sclkPrev <= 1'b0;
    end else begin
      sclkQ    <= {sclkQ[STAGES-2:0], sclk};
      csQ      <= {csQ[STAGES-2:0], csN};
      siQ      <= {siQ[STAGES-2:0], si};
      sclkPrev <= sclkQ[LAST];
    end
  end

  assign sclkRise = sclkQ[LAST] & ~sclkPrev;
  assign sclkFall = ~sclkQ[LAST] & sclkPrev;
  assign csActive = ~csQ[LAST];
  assign siS      = siQ[LAST];

endmodule

// File: rtl/spi_rd_ctrl.sv
module spi_rd_ctrl
  import spi_rd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclkRise,
  input  logic       sclkFall,
  input  logic       csActive,
  input  logic       busy,
  input  logic [7:0] cmdByte,
  output dpCtrl_t    ctl
);

  localparam int CNT_W = $clog2(ADDR_BITS_IN);
  localparam logic [CNT_W-1:0] LAST_BYTE_BIT = CNT_W'(7);
  localparam logic [CNT_W-1:0] LAST_ADDR_BIT = CNT_W'(ADDR_BITS_IN - 1);
  localparam logic [CNT_W-1:0] LAST_DUMMY    = CNT_W'(DUMMY_BITS - 1);

  rdState_t         state;
  logic [CNT_W-1:0] bitCnt;
  logic             fastCmd;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_CMD;
      bitCnt  <= '0;
      fastCmd <= 1'b0;
    end else if (!csActive) begin
      state   <= ST_CMD;
      bitCnt  <= '0;
      fastCmd <= 1'b0;
    end else begin
      unique case (state)
        ST_CMD: if (sclkRise) begin
          if (bitCnt == LAST_BYTE_BIT) begin
            bitCnt <= '0;
            if (cmdByte == OP_READ) begin
              state   <= ST_ADDR;
              fastCmd <= 1'b0;
            end else if (cmdByte == OP_FAST && !busy) begin
              state   <= ST_ADDR;
              fastCmd <= 1'b1;
            end else begin
              state <= ST_IGNORE;
            end
          end else begin
            bitCnt <= bitCnt + CNT_W'(1);
          end
        end
        ST_ADDR: if (sclkRise) begin
          if (bitCnt == LAST_ADDR_BIT) begin
            bitCnt <= '0;
            state  <= fastCmd ? ST_DUMMY : ST_DATA;
          end else begin
            bitCnt <= bitCnt + CNT_W'(1);
          end
        end
        ST_DUMMY: if (sclkRise) begin
          if (bitCnt == LAST_DUMMY) begin
            bitCnt <= '0;
            state  <= ST_DATA;
          end else begin
            bitCnt <= bitCnt + CNT_W'(1);
          end
        end
        ST_DATA: if (sclkFall) begin
          bitCnt <= (bitCnt == LAST_BYTE_BIT) ? '0 : bitCnt + CNT_W'(1);
        end
        default: state <= ST_IGNORE;
      endcase
    end
  end

  always_comb begin
    ctl          = '0;
    ctl.oeClr    = !csActive;
    ctl.shiftIn  = csActive && sclkRise && (state == ST_CMD || state == ST_ADDR);
    ctl.loadAddr = csActive && sclkRise && state == ST_ADDR && bitCnt == LAST_ADDR_BIT;
    ctl.loadOut  = csActive && sclkFall && state == ST_DATA && bitCnt == '0;
    ctl.shiftOut = csActive && sclkFall && state == ST_DATA && bitCnt != '0;
    ctl.fetch    = ctl.loadAddr || ctl.loadOut;
  end

endmodule

// File: rtl/spi_rd_dp.sv
module spi_rd_dp
  import spi_rd_pkg::*;
#(
  parameter int ADDR_W = 21
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           ctl,
  input  logic              siS,
  output logic [7:0]        cmdByte,
  output logic              so,
  output logic              soOe,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [7:0]        memRdata
);

  localparam int IN_W = ADDR_BITS_IN - 1;

  logic [IN_W-1:0]   inShift;
  logic [ADDR_W-1:0] addrQ;
  logic [7:0]        nextByte;
  logic [7:0]        outShift;
  logic              oeQ;
  logic              rdEnQ;
  logic              rdValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inShift  <= '0;
      addrQ    <= '0;
      nextByte <= '0;
      outShift <= '0;
      oeQ      <= 1'b0;
      rdEnQ    <= 1'b0;
      rdValid  <= 1'b0;
    end else begin
      if (ctl.shiftIn) inShift <= {inShift[IN_W-2:0], siS};

      if (ctl.loadAddr)  addrQ <= ADDR_W'({inShift, siS});
      else if (rdValid)  addrQ <= addrQ + ADDR_W'(1);

      rdEnQ   <= ctl.fetch;
      rdValid <= rdEnQ;
      if (rdValid) nextByte <= memRdata;

      if (ctl.loadOut)       outShift <= nextByte;
      else if (ctl.shiftOut) outShift <= {outShift[6:0], 1'b0};

      if (ctl.oeClr)        oeQ <= 1'b0;
      else if (ctl.loadOut) oeQ <= 1'b1;
    end
  end

  assign cmdByte = {inShift[6:0], siS};
  assign so      = outShift[7];
  assign soOe    = oeQ;
  assign memRdEn = rdEnQ;
  assign memAddr = addrQ;

endmodule

// File: rtl/spi_flash_reader.sv
module spi_flash_reader
  import spi_rd_pkg::*;
#(
  parameter int MEM_BYTES   = 2097152,
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W     = $clog2(MEM_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclk,
  input  logic              csN,
  input  logic              si,
  input  logic              busy,
  output logic              so,
  output logic              soOe,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [7:0]        memRdata
);

  logic       sclkRise;
  logic       sclkFall;
  logic       csActive;
  logic       siS;
  logic [7:0] cmdByte;
  dpCtrl_t    ctl;

  spi_rd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csN(csN), .si(si),
    .sclkRise(sclkRise), .sclkFall(sclkFall), .csActive(csActive), .siS(siS)
  );

  spi_rd_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .sclkRise(sclkRise), .sclkFall(sclkFall),
    .csActive(csActive), .busy(busy), .cmdByte(cmdByte), .ctl(ctl)
  );

  spi_rd_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .siS(siS), .cmdByte(cmdByte),
    .so(so), .soOe(soOe), .memRdEn(memRdEn), .memAddr(memAddr),
    .memRdata(memRdata)
  );

endmodule

// File: rtl/spi_rd_checker.sv
module spi_rd_checker #(
  parameter int ADDR_W = 21
) (
  input logic              clk,
  input logic              rstN,
  input logic              so,
  input logic              soOe,
  input logic              memRdEn,
  input logic [ADDR_W-1:0] memAddr,
  input logic              csActive,
  input logic              sclkFall
);

  a_r3_so_moves_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    (soOe && $past(soOe) && !$past(sclkFall)) |-> $stable(so));

  a_r7_oe_off_when_deselected: assert property (@(posedge clk) disable iff (!rstN)
    (!csActive && $past(!csActive)) |-> !soOe);

  a_r7_fetch_needs_select: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |-> $past(csActive));

  a_r5_single_strobe: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |=> !memRdEn);

  a_r6_addr_steps_by_one: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |=> ##1 (memAddr == ADDR_W'($past(memAddr, 2) + ADDR_W'(1))));

endmodule

bind spi_flash_reader spi_rd_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .so(so), .soOe(soOe), .memRdEn(memRdEn),
  .memAddr(memAddr), .csActive(csActive), .sclkFall(sclkFall)
);

// File: tb/tb_spi_flash_reader.sv
module tb_spi_flash_reader;

  localparam int MEM_BYTES = 2097152;
  localparam int AW        = $clog2(MEM_BYTES);
  localparam int H         = 8;   // clocks per SCLK level

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          sclk = 1'b0;
  logic          csN = 1'b1;
  logic          si = 1'b0;
  logic          busy = 1'b0;
  logic          so;
  logic          soOe;
  logic          memRdEn;
  logic [AW-1:0] memAddr;
  logic [7:0]    memRdata = 8'h00;

  int nChecks = 0;
  int nErrors = 0;
  int nFetch  = 0;

  always #4 clk = ~clk;

  spi_flash_reader #(.MEM_BYTES(MEM_BYTES)) dut (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csN(csN), .si(si), .busy(busy),
    .so(so), .soOe(soOe), .memRdEn(memRdEn), .memAddr(memAddr),
    .memRdata(memRdata)
  );

  function automatic logic [7:0] memByte(input logic [AW-1:0] a);
    logic [7:0] lo;
    lo = a[7:0] * 8'd29;
    return lo ^ a[15:8] ^ {a[20:16], 3'b101};
  endfunction

  // array model: one clock of read latency
  always @(posedge clk) begin
    if (memRdEn) memRdata <= memByte(memAddr);
    if (rstN && memRdEn) nFetch++;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one SCLK period: low phase (SO sampled at its end), then high phase
  task automatic clockBit(input bit siVal, input bit expOe, input bit expSo,
                          input string req);
    bit seen;
    si = siVal;
    waitClk(H);
    check(soOe == expOe, req, "soOe", soOe, expOe);
    if (expOe) check(so == expSo, req, "so bit", so, expSo);
    seen = so;
    sclk = 1'b1;
    waitClk(H / 2);
    if (expOe) check(so == seen, "R3", "so held in high phase", so, seen);
    waitClk(H / 2);
    sclk = 1'b0;
  endtask

  // full command; nData = data clocks to run, expData = stream is expected
  task automatic runCmd(input logic [7:0] op, input logic [23:0] addr,
                        input bit fast, input int nData, input bit expData,
                        input string req);
    bit expQ[$];
    int f0;
    logic [AW-1:0] a;
    a = AW'(addr);
    for (int i = 0; i < (nData + 7) / 8; i++) begin
      logic [7:0] b;
      b = memByte(AW'(a + AW'(i)));
      for (int k = 7; k >= 0; k--) expQ.push_back(b[k]);
    end
    f0 = nFetch;
    csN = 1'b0;
    waitClk(H);
    for (int i = 7; i >= 0; i--) clockBit(op[i], 1'b0, 1'b0, "R11");
    for (int i = 23; i >= 0; i--) clockBit(addr[i], 1'b0, 1'b0, "R11");
    if (fast) for (int i = 0; i < 8; i++) clockBit(1'b1, 1'b0, 1'b0, "R11");
    for (int i = 0; i < nData; i++) begin
      bit e;
      e = expQ.pop_front();
      clockBit(1'b0, expData, e, req);
    end
    waitClk(H);
    csN = 1'b1;
    waitClk(H);
    check(soOe == 1'b0, "R7", "soOe after deselect", soOe, 0);
    if (!expData) check(nFetch == f0, req, "memory reads on refused command", nFetch - f0, 0);
    waitClk(H);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nErrors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  initial begin
    waitClk(5);
    check(soOe == 1'b0, "R1", "soOe in reset", soOe, 0);
    check(memRdEn == 1'b0, "R1", "memRdEn in reset", memRdEn, 0);
    rstN = 1'b1;
    waitClk(5);
    check(soOe == 1'b0 && memRdEn == 1'b0, "R1", "idle after reset", soOe, 0);

    // R2 / R5: plain read, three bytes
    runCmd(8'h03, 24'h012345, 1'b0, 24, 1'b1, "R2");
    // R4: fast read with dummy byte
    runCmd(8'h0B, 24'h0A0B0C, 1'b1, 16, 1'b1, "R4");
    // R5: different start, four bytes
    runCmd(8'h03, 24'h00FFFE, 1'b0, 32, 1'b1, "R5");
    // R6: wrap past the top, upper address bits ignored
    runCmd(8'h03, 24'h1FFFFE, 1'b0, 32, 1'b1, "R6");
    runCmd(8'h0B, 24'hFFFFFF, 1'b1, 16, 1'b1, "R6");
    // R7: abort mid-byte, then a normal command
    runCmd(8'h03, 24'h000100, 1'b0, 12, 1'b1, "R7");
    runCmd(8'h03, 24'h000200, 1'b0, 16, 1'b1, "R7");
    // R8: fast read refused while busy
    busy = 1'b1;
    runCmd(8'h0B, 24'h000300, 1'b1, 16, 1'b0, "R8");
    // R9: plain read unaffected by busy
    runCmd(8'h03, 24'h000300, 1'b0, 16, 1'b1, "R9");
    busy = 1'b0;
    // R10: unknown opcodes, address bits shaped like a read opcode
    runCmd(8'h05, 24'h030303, 1'b0, 16, 1'b0, "R10");
    runCmd(8'h3B, 24'h0B0300, 1'b1, 16, 1'b0, "R10");
    // R8 recovers once idle
    runCmd(8'h0B, 24'h000300, 1'b1, 8, 1'b1, "R8");

    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

endmodule